// File: doc/BRIEF.md
# Condition Code Flag Generator

This block produces the updated condition-code byte of a small CPU after an add, subtract, test or shift. The datapath presents the two operands, the result it has already computed, a two-bit operation select, a width select (byte or word) and the flag byte as it stands. The block returns a new flag byte in which the negative, zero, overflow and carry bits reflect the operation. Every bit the operation does not touch keeps its incoming value.

Carry and overflow are formed from the sign bits of the operands and the result only, so no adder carry chain is needed here. In byte mode only the low byte of each input is looked at. The new byte is registered, and it is loaded only on cycles where the enable is high.

Flag byte layout, from bit 7 down to bit 0: S, X, H, I, N, Z, V, C. Operation select: 2'b00 add, 2'b01 subtract, 2'b10 test, 2'b11 shift. Width select: 0 means byte (sign bit 7), 1 means word (sign bit 15).

Top module: `ccgen_flags`

## Requirements
- R1: While rst_n is low, ccr_out is 8'h00.
- R2: In a cycle where en is low, ccr_out keeps its value.
- R3: When en is high at a rising clock edge, ccr_out takes the new flag byte at that edge, so the result is visible one cycle after the inputs.
- R4: Bits 7..4 (S, X, H, I) of ccr_out equal bits 7..4 of ccr_in for every operation.
- R5: N (bit 3) equals the result sign bit, which is bit 7 in byte mode and bit 15 in word mode. Z (bit 2) is 1 exactly when the result is zero in the selected width, and in byte mode bits 15..8 of the result are ignored.
- R6: For add (op 2'b00), C (bit 0) is the carry out of the sign position, which is the sign bit of (a&b)|(b&~r)|(a&~r).
- R7: For add, V (bit 1) is the sign bit of (a&b&~r)|(~a&~b&r), which is signed overflow.
- R8: For subtract (op 2'b01), C is the borrow, which is the sign bit of (~a&b)|(b&r)|(~a&r).
- R9: For subtract, V is the sign bit of (a&~b&~r)|(~a&b&r).
- R10: For test (op 2'b10), V is cleared and C is copied from ccr_in bit 0.
- R11: For shift (op 2'b11), C is copied from ccr_in bit 0, and V equals the new N XOR that C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load the new flag byte this cycle |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 test, 11 shift |
| wide | input | 1 | 1 selects word width, 0 selects byte width |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| ccr_in | input | 8 | Current flag byte |
| ccr_out | output | 8 | Registered updated flag byte |

## Verification
For a shift, two updates land in the same cycle and one feeds the other: the new negative flag is computed, and the overflow flag is formed from that new N together with the incoming carry. The bench provokes this by driving shifts in which the result sign and the incoming carry take all four combinations. It judges V against N XOR C taken from its own model. A second collision comes from byte mode with a non-zero upper result byte: Z must follow the low byte, while N must come from bit 7. Directed vectors with a result of 16'hFF00 are used to provoke this case.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;
  typedef enum logic [1:0] {
    CC_ADD = 2'b00,
    CC_SUB = 2'b01,
    CC_TST = 2'b10,
    CC_SHF = 2'b11
  } cc_op_e;

  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_BYTE_W = 8;
endpackage

// File: rtl/ccgen_signs.sv
module ccgen_signs #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = DATA_W / 2
) (
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  output logic              a_msb,
  output logic              b_msb,
  output logic              r_msb,
  output logic              r_zero
);
  localparam int WMSB = DATA_W - 1;
  localparam int NMSB = NARROW_W - 1;

  always_comb begin
    if (wide) begin
      a_msb  = opa[WMSB];
      b_msb  = opb[WMSB];
      r_msb  = res[WMSB];
      r_zero = (res == '0);
    end else begin
      a_msb  = opa[NMSB];
      b_msb  = opb[NMSB];
      r_msb  = res[NMSB];
      r_zero = (res[NMSB:0] == '0);
    end
  end
endmodule

// File: rtl/ccgen_arith.sv
module ccgen_arith (
  input  logic is_sub,
  input  logic a_msb,
  input  logic b_msb,
  input  logic r_msb,
  output logic c_out,
  output logic v_out
);
  logic add_c, add_v, sub_c, sub_v;

  always_comb begin
    add_c = (a_msb & b_msb) | (b_msb & ~r_msb) | (a_msb & ~r_msb);
    add_v = (a_msb & b_msb & ~r_msb) | (~a_msb & ~b_msb & r_msb);
    sub_c = (~a_msb & b_msb) | (b_msb & r_msb) | (~a_msb & r_msb);
    sub_v = (a_msb & ~b_msb & ~r_msb) | (~a_msb & b_msb & r_msb);
    c_out = is_sub ? sub_c : add_c;
    v_out = is_sub ? sub_v : add_v;
  end
endmodule

// File: rtl/ccgen_flags.sv
module ccgen_flags
  import ccgen_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           op,
  input  logic                 wide,
  input  logic [DATA_W-1:0]    opa,
  input  logic [DATA_W-1:0]    opb,
  input  logic [DATA_W-1:0]    res,
  input  logic [CC_BYTE_W-1:0] ccr_in,
  output logic [CC_BYTE_W-1:0] ccr_out
);
  localparam int NARROW_W = DATA_W / 2;

  cc_op_e op_e;
  logic a_msb, b_msb, r_msb, r_zero;
  logic ar_c, ar_v;
  logic [CC_BYTE_W-1:0] ccr_nxt;

  assign op_e = cc_op_e'(op);

  ccgen_signs #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_signs (
    .wide   (wide),
    .opa    (opa),
    .opb    (opb),
    .res    (res),
    .a_msb  (a_msb),
    .b_msb  (b_msb),
    .r_msb  (r_msb),
    .r_zero (r_zero)
  );

  ccgen_arith u_arith (
    .is_sub (op_e == CC_SUB),
    .a_msb  (a_msb),
    .b_msb  (b_msb),
    .r_msb  (r_msb),
    .c_out  (ar_c),
    .v_out  (ar_v)
  );

  always_comb begin
    ccr_nxt       = ccr_in;
    ccr_nxt[CC_N] = r_msb;
    ccr_nxt[CC_Z] = r_zero;
    unique case (op_e)
      CC_ADD, CC_SUB: begin
        ccr_nxt[CC_C] = ar_c;
        ccr_nxt[CC_V] = ar_v;
      end
      CC_TST:  ccr_nxt[CC_V] = 1'b0;
      CC_SHF:  ccr_nxt[CC_V] = r_msb ^ ccr_in[CC_C];
      default: ccr_nxt[CC_V] = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ccr_out <= '0;
    else if (en) ccr_out <= ccr_nxt;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ccr_out));
  a_r4_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ccr_out[7:4] == $past(ccr_in[7:4]));
  a_r5_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wide && res[NARROW_W-1:0] == '0) |=> ccr_out[CC_Z]);
  a_r5_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wide) |=> ccr_out[CC_N] == $past(res[DATA_W-1]));
  a_r10_tst_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'b10) |=> (!ccr_out[CC_V] && ccr_out[CC_C] == $past(ccr_in[CC_C])));
  a_r11_shift_v: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'b11) |=> ccr_out[CC_V] == (ccr_out[CC_N] ^ ccr_out[CC_C]));
endmodule

// File: tb/ccgen_flags_test.sv
module ccgen_flags_test;
  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic [1:0] op;
  logic wide;
  logic [15:0] opa, opb, res;
  logic [7:0] ccr_in, ccr_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ccr;
  string exp_tag;
  bit done = 0;

  always #5 clk = ~clk;

  ccgen_flags uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .wide(wide),
    .opa(opa), .opb(opb), .res(res), .ccr_in(ccr_in), .ccr_out(ccr_out)
  );

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Drive one vector; for add/subtract the result is formed arithmetically with carry-in k.
  task automatic drive(input bit e, input int o, input bit w, input int a, input int b,
                       input int r, input int k, input int cc);
    int m, h, ua, ub, sa, sb, s, rr;
    bit n, z, c, v;
    logic [7:0] nx;
    m  = w ? 32'hFFFF : 32'hFF;
    h  = w ? 32'h8000 : 32'h80;
    ua = a & m; ub = b & m;
    sa = (ua >= h) ? ua - 2*h : ua;
    sb = (ub >= h) ? ub - 2*h : ub;
    rr = r;
    c  = cc[0];
    v  = cc[1];
    case (o)
      0: begin
        s = ua + ub + k; rr = (r & ~m) | (s & m);
        c = (s > m);
        s = sa + sb + k; v = (s > h - 1) || (s < -h);
      end
      1: begin
        s = ua - ub - k; rr = (r & ~m) | (s & m);
        c = (ua < ub + k);
        s = sa - sb - k; v = (s > h - 1) || (s < -h);
      end
      default: ;
    endcase
    n = ((rr & h) != 0);
    z = ((rr & m) == 0);
    if (o == 2) v = 1'b0;
    if (o == 3) v = n ^ cc[0];
    nx = {cc[7:4], n, z, v, c};
    en = e; op = o[1:0]; wide = w;
    opa = a[15:0]; opb = b[15:0]; res = rr[15:0]; ccr_in = cc[7:0];
    if (e) begin
      exp_ccr = nx;
      exp_tag = (o == 0) ? "R6 R7" : (o == 1) ? "R8 R9" : (o == 2) ? "R10" : "R11";
    end else exp_tag = "R2";
  endtask

  task automatic compare();
    chk({exp_tag, " R4 upper"}, ccr_out[7:4], exp_ccr[7:4]);
    chk({exp_tag, " R5 nz"}, ccr_out[3:2], exp_ccr[3:2]);
    chk({exp_tag, " R3 vc"}, ccr_out[1:0], exp_ccr[1:0]);
  endtask

  task automatic step(input bit e, input int o, input bit w, input int a, input int b,
                      input int r, input int k, input int cc);
    drive(e, o, w, a, b, r, k, cc);
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    exp_ccr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset", ccr_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", ccr_out, 8'h00);

    // Directed boundaries
    step(1, 0, 0, 8'h7F, 8'h01, 0, 0, 8'hA0);       // R7 byte overflow
    chk("R7 add 7F+01 V", ccr_out[1], 1);
    step(1, 0, 0, 8'hFF, 8'h01, 0, 0, 8'h00);       // R6 carry, zero
    chk("R6 add FF+01 C", ccr_out[0], 1);
    step(1, 1, 0, 8'h00, 8'h01, 0, 0, 8'h00);       // R8 borrow
    chk("R8 sub 00-01 C", ccr_out[0], 1);
    step(1, 1, 1, 16'h8000, 16'h0001, 0, 0, 8'h00); // R9 word overflow
    chk("R9 sub 8000-0001 V", ccr_out[1], 1);
    step(1, 2, 0, 0, 0, 16'hFF00, 0, 8'h53);        // R5 upper byte ignored, R10
    chk("R5 byte zero ignores upper", ccr_out[2], 1);
    chk("R10 test C kept", ccr_out[0], 1);
    step(1, 3, 1, 0, 0, 16'h8000, 0, 8'h01);        // R11 N=1 C=1 -> V=0
    chk("R11 shift V", ccr_out[1], 0);
    step(1, 3, 0, 0, 0, 16'h0080, 0, 8'h00);        // R11 N=1 C=0 -> V=1
    chk("R11 shift V", ccr_out[1], 1);
    step(0, 0, 0, 8'h7F, 8'h7F, 0, 1, 8'hFF);       // R2 hold
    chk("R2 hold value", ccr_out, 8'h0A);

    // Random traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 2,
           $urandom & 16'hFFFF, $urandom & 16'hFFFF,
           (($urandom % 4) == 0) ? ($urandom & 16'hFF00) : ($urandom & 16'hFFFF),
           $urandom % 2, $urandom & 8'hFF);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule